// File: doc/BRIEF.md
# Quad Message Queue Register File

This block holds four independent 32-word by 32-bit queues that carry message handles between a host bus and a local bus: an inbound free list, an inbound post list, an outbound free list and an outbound post list. The block is reached through one register interface that both bus sides share. That interface has a word address, a read strobe, a write strobe, write data and registered read data.

Four word-aligned ports reach the queues. The read side and the write side of one port address act on two different queues. A read pops the queue that the port maps for reads. A write pushes the queue that the port maps for writes. A read of an empty queue does not stall. It returns all ones and leaves the queue untouched. A write to a full queue is dropped, and an overflow pulse is raised for that queue.

Each queue is run by a small state machine with three states. `QS_EMPTY` moves to `QS_PART` on an accepted push. `QS_PART` moves to `QS_FULL` on a push that stores the last free slot. `QS_PART` moves to `QS_EMPTY` on a pop that takes the last stored word. `QS_FULL` moves back to `QS_PART` on an accepted pop. In every other case the state holds. An occupancy counter one bit wider than the pointers lets the state machine tell a full queue from an empty one.

Top module: `msgq_regfile`

## Requirements
- R1: Each queue holds up to 32 words of 32 bits and returns them in the order they were written.
- R2: Queue indices are 0 inbound free, 1 inbound post, 2 outbound free and 3 outbound post. Address 0x40 reads queue 0 and writes queue 1. Address 0x44 reads queue 3 and writes queue 2. Address 0x48 reads queue 1 and writes queue 0. Address 0x4C reads queue 2 and writes queue 3.
- R3: Read data is registered. It appears in the cycle after the clock edge that samples the read strobe, and it holds its value while no read is made.
- R4: A read from an empty queue returns 0xFFFFFFFF and does not move that queue's pointers.
- R5: A write to a full queue stores nothing and leaves the queue's contents and order unchanged.
- R6: A write to a full queue raises bit i of `q_ovf`, where i is the target queue, for exactly the one cycle after the edge that sampled the write. No other bit is raised.
- R7: Bit i of `q_empty` and bit i of `q_full` describe queue i. Both flags update in the cycle after the edge that changes the occupancy, and full means 32 words are stored.
- R8: A read and a write on the same cycle go to the same port address, reach two different queues, and are both carried out.
- R9: A read from any address other than the four ports returns zero, and a write to such an address changes no queue.
- R10: Synchronous reset empties every queue, clears `q_ovf` and clears the read data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address of the access |
| rd_en | input | 1 | Read strobe, one pop per cycle |
| wr_en | input | 1 | Write strobe, one push per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| q_empty | output | 4 | Per-queue empty flag |
| q_full | output | 4 | Per-queue full flag |
| q_ovf | output | 4 | Per-queue overflow pulse |

## Verification
The assertions assume that one shared address serves both strobes, so a single cycle can never push and pop the same queue. They also assume the bus changes inputs only between clock edges. The bench drives every input on the falling edge and uses one address per cycle, so it stays inside both assumptions. The full-queue and empty-queue properties look only at cycles where a single strobe acts on a queue, and the stimulus reaches both limits that way before it mixes reads and writes.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    localparam int QUEUES = 4;

    typedef enum logic [1:0] {
        QS_EMPTY = 2'd0,
        QS_PART  = 2'd1,
        QS_FULL  = 2'd2
    } qstate_e;

    // Queue index for the read side of a port (port = addr[3:2])
    function automatic logic [1:0] port_rd_queue(input logic [1:0] port);
        logic [1:0] q;
        unique case (port)
            2'd0: q = 2'd0;
            2'd1: q = 2'd3;
            2'd2: q = 2'd1;
            2'd3: q = 2'd2;
            default: q = 2'd0;
        endcase
        return q;
    endfunction

    // Queue index for the write side of a port
    function automatic logic [1:0] port_wr_queue(input logic [1:0] port);
        logic [1:0] q;
        unique case (port)
            2'd0: q = 2'd1;
            2'd1: q = 2'd2;
            2'd2: q = 2'd0;
            2'd3: q = 2'd3;
            default: q = 2'd0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
    import msgq_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [7:0]  BASE   = 8'h40
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [QUEUES-1:0]  rd_sel,
    output logic [QUEUES-1:0]  wr_sel
);

    logic [ADDR_W-1:0] base_ext;
    logic [1:0]        port;
    logic [1:0]        rq;
    logic [1:0]        wq;

    assign base_ext = ADDR_W'(BASE);
    assign port     = addr[3:2];
    assign hit      = (addr[ADDR_W-1:4] == base_ext[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
    assign rq       = port_rd_queue(port);
    assign wq       = port_wr_queue(port);

    for (genvar g = 0; g < QUEUES; g++) begin : g_sel
        assign rd_sel[g] = hit && (rq == 2'(g));
        assign wr_sel[g] = hit && (wq == 2'(g));
    end

endmodule

// File: rtl/msgq_queue.sv
module msgq_queue
    import msgq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    output logic              ovf
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(DEPTH - 1);

    qstate_e           state_q, state_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    logic              push_ok, pop_ok;

    assign push_ok = push && (state_q != QS_FULL);
    assign pop_ok  = pop  && (state_q != QS_EMPTY);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= QS_EMPTY;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_EMPTY: begin
                if (push_ok && !pop_ok) state_d = QS_PART;
            end
            QS_PART: begin
                if (push_ok && !pop_ok && count == CNT_LAST)
                    state_d = QS_FULL;
                else if (pop_ok && !push_ok && count == CNT_ONE)
                    state_d = QS_EMPTY;
            end
            QS_FULL: begin
                if (pop_ok && !push_ok) state_d = QS_PART;
            end
            default: state_d = QS_EMPTY;
        endcase
    end

    // Output decode
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            QS_EMPTY: empty = 1'b1;
            QS_PART:  ;
            QS_FULL:  full  = 1'b1;
            default:  empty = 1'b1;
        endcase
    end

    // Pointers, occupancy and overflow pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && (state_q == QS_FULL);
            if (push_ok) head <= (head == PTR_END) ? '0 : head + 1'b1;
            if (pop_ok)  tail <= (tail == PTR_END) ? '0 : tail + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    // Storage
    always_ff @(posedge clk) begin
        if (push_ok) mem[head] <= wdata;
    end

    assign head_data = mem[tail];

    // R7: state flags agree with the occupancy counter
    a_r7_empty_count: assert property (@(posedge clk) disable iff (rst)
        empty == (count == '0));
    a_r7_full_count: assert property (@(posedge clk) disable iff (rst)
        full == (count == CNT_W'(DEPTH)));

    // R5: a push into a full queue moves neither occupancy nor write pointer
    a_r5_full_hold: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> ($stable(count) && $stable(head)));

    // R4: a pop of an empty queue leaves the read pointer alone
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> ($stable(tail) && empty));

    // R6: an overflow pulse only follows a cycle in which the queue was full
    a_r6_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(full));

endmodule

// File: rtl/msgq_regfile.sv
module msgq_regfile
    import msgq_pkg::*;
#(
    parameter int         ADDR_W = 8,
    parameter int         DATA_W = 32,
    parameter int         DEPTH  = 32,
    parameter logic [7:0] BASE   = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [QUEUES-1:0] q_empty,
    output logic [QUEUES-1:0] q_full,
    output logic [QUEUES-1:0] q_ovf
);

    localparam logic [DATA_W-1:0] EMPTY_WORD = '1;

    logic              hit;
    logic [QUEUES-1:0] rd_sel, wr_sel;
    logic [DATA_W-1:0] head_data [QUEUES];
    logic [DATA_W-1:0] rd_word;

    msgq_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE)
    ) u_decode (
        .addr   (addr),
        .hit    (hit),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    for (genvar g = 0; g < QUEUES; g++) begin : g_queue
        msgq_queue #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W)
        ) u_queue (
            .clk       (clk),
            .rst       (rst),
            .push      (wr_en && wr_sel[g]),
            .pop       (rd_en && rd_sel[g]),
            .wdata     (wdata),
            .head_data (head_data[g]),
            .empty     (q_empty[g]),
            .full      (q_full[g]),
            .ovf       (q_ovf[g])
        );
    end

    // Read word selection: unmapped reads zero, empty queue reads all ones
    always_comb begin
        rd_word = hit ? EMPTY_WORD : '0;
        for (int i = 0; i < QUEUES; i++) begin
            if (rd_sel[i] && !q_empty[i]) rd_word = head_data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    // R2, R8: one address never selects the same queue for both directions
    a_r8_sel_disjoint: assert property (@(posedge clk) disable iff (rst)
        ((rd_sel & wr_sel) == '0) && $onehot0(rd_sel) && $onehot0(wr_sel));

    // R3: read data holds when no read was sampled
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rdata));

    // R9: unmapped addresses touch no queue
    a_r9_unmapped_idle: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (rd_sel == '0 && wr_sel == '0));

endmodule

// File: tb/sim_msgq_regfile.sv
module sim_msgq_regfile;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  q_empty, q_full, q_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model
    logic [31:0] mq [4][$];
    logic [31:0] exp_rdata = '0;
    logic [3:0]  exp_ovf   = '0;

    always #5 clk = ~clk;

    msgq_regfile u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .q_empty(q_empty), .q_full(q_full),
        .q_ovf(q_ovf)
    );

    function automatic bit port_map(input logic [7:0] a, output int rq, output int wq);
        rq = 0; wq = 0;
        case (a)
            8'h40: begin rq = 0; wq = 1; return 1; end
            8'h44: begin rq = 3; wq = 2; return 1; end
            8'h48: begin rq = 1; wq = 0; return 1; end
            8'h4C: begin rq = 2; wq = 3; return 1; end
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int  rq, wq;
        bit  m;
        exp_ovf = '0;
        if (rst) begin
            for (int i = 0; i < 4; i++) mq[i].delete();
            exp_rdata = '0;
            return;
        end
        m = port_map(addr, rq, wq);
        if (rd_en) begin
            if (!m)                  exp_rdata = '0;
            else if (mq[rq].size() == 0) exp_rdata = 32'hFFFF_FFFF;
            else                     exp_rdata = mq[rq].pop_front();
        end
        if (wr_en && m) begin
            if (mq[wq].size() == DEPTH) exp_ovf[wq] = 1'b1;
            else                        mq[wq].push_back(wdata);
        end
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at falling edge
    task automatic step(input string tag, input bit r, input bit w,
                        input logic [7:0] a, input logic [31:0] d, input bit rs = 0);
        logic [3:0] e_emp, e_full;
        rst = rs; rd_en = r; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            e_emp[i]  = (mq[i].size() == 0);
            e_full[i] = (mq[i].size() == DEPTH);
        end
        check(tag, "rdata",   rdata, exp_rdata);
        check(tag, "q_empty", {28'b0, q_empty}, {28'b0, e_emp});
        check(tag, "q_full",  {28'b0, q_full},  {28'b0, e_full});
        check(tag, "q_ovf",   {28'b0, q_ovf},   {28'b0, exp_ovf});
        rd_en = 0; wr_en = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset state
        for (int i = 0; i < 3; i++) step("R10", 0, 0, 8'h00, 0, 1);

        // R4: empty reads on every port
        step("R4", 1, 0, 8'h40, 0);
        step("R4", 1, 0, 8'h44, 0);
        step("R4", 1, 0, 8'h48, 0);
        step("R4", 1, 0, 8'h4C, 0);

        // R2: each write port reaches its queue, each read port drains the other
        step("R2", 0, 1, 8'h40, 32'h1111_0001);
        step("R2", 0, 1, 8'h44, 32'h2222_0002);
        step("R2", 0, 1, 8'h48, 32'h3333_0003);
        step("R2", 0, 1, 8'h4C, 32'h4444_0004);
        step("R3", 0, 0, 8'h00, 0);
        step("R2", 1, 0, 8'h48, 0);
        step("R3", 0, 0, 8'h48, 0);
        step("R2", 1, 0, 8'h4C, 0);
        step("R2", 1, 0, 8'h40, 0);
        step("R2", 1, 0, 8'h44, 0);
        step("R3", 0, 0, 8'h44, 0);

        // R9: unmapped accesses
        step("R9", 0, 1, 8'h50, 32'hDEAD_BEEF);
        step("R9", 0, 1, 8'h42, 32'hDEAD_BEEF);
        step("R9", 1, 0, 8'h3C, 0);
        step("R9", 1, 0, 8'h48, 0);

        // R1 R7: fill inbound post to 32 words
        for (int i = 0; i < DEPTH; i++) step("R7", 0, 1, 8'h40, 32'hA500_0000 + i);
        // R5 R6: writes to a full queue
        step("R6", 0, 1, 8'h40, 32'hBAD0_0001);
        step("R6", 0, 0, 8'h40, 0);
        step("R5", 0, 1, 8'h40, 32'hBAD0_0002);
        // R8: read and write same port, different queues, while post is full
        step("R8", 1, 1, 8'h48, 32'hC000_0001);
        step("R8", 1, 1, 8'h48, 32'hC000_0002);
        // R1: drain in order, then run past empty
        for (int i = 0; i < DEPTH; i++) step("R1", 1, 0, 8'h48, 0);
        step("R4", 1, 0, 8'h48, 0);
        step("R8", 1, 0, 8'h40, 0);
        step("R8", 1, 0, 8'h40, 0);
        step("R4", 1, 0, 8'h40, 0);

        // R6: fill outbound post and overflow it; other bits stay low
        for (int i = 0; i < DEPTH; i++) step("R7", 0, 1, 8'h4C, 32'h0B00_0000 + i);
        step("R6", 0, 1, 8'h4C, 32'hFFFF_0000);
        step("R1", 1, 0, 8'h44, 0);
        step("R7", 0, 1, 8'h4C, 32'h0B00_00FF);
        step("R6", 0, 1, 8'h4C, 32'h0);

        // R10: reset empties queues mid-run
        step("R10", 0, 0, 8'h00, 0, 1);
        step("R10", 1, 0, 8'h44, 0);
        step("R10", 0, 0, 8'h00, 0);

        // interleaved traffic on all ports
        for (int i = 0; i < 200; i++) begin
            logic [7:0] a;
            a = 8'h40 + 8'((i * 7 % 4) * 4);
            step("R1", (i % 3) != 0, (i % 5) != 1, a, 32'h5000_0000 ^ (i * 32'h0101_0101));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule